// File: doc/BRIEF.md
# Tree-Systolic Delayed-LMS Adaptive FIR Filter

This block is an adaptive FIR filter with `N_TAPS` coefficients that learns from a desired-response stream. Coefficients are adjusted with a delayed least-mean-square rule. The taps are split into `N_TAPS / 2^TREE_P` identical processing groups. Inside a group, the tap products are summed by a balanced binary adder tree of depth `TREE_P`, with no register between taps. A single register on the partial-sum path sits at each group boundary, and each group connects only to its neighbours. The longest combinational path is therefore one multiply plus one group's adder tree, and a new sample can be taken on every clock.

A sample pair (`x_in`, `d_in`) is accepted on each clock where `in_valid` is high. When `in_valid` is low, the whole pipeline stands still. The filter output is the full-precision sum shifted right by `FRAC_W` with floor rounding. The error is the desired sample minus that output, with the desired sample delayed internally to line up with the output.

The error is passed back through a registered chain that holds one copy per group. Each copy drives only that group's `2^TREE_P` coefficient updaters. The step size is `2^-MU_SHIFT`. Coefficients saturate at their signed limits instead of wrapping.

A two-state controller sequences the outputs:
- `ST_FILL` is entered on reset. It counts accepted samples while the pipeline fills, and it holds the outputs at zero.
- The transition `ST_FILL -> ST_RUN` is taken on the accepted sample that arrives after `M+1` samples have already been taken (M = number of groups).
- `ST_RUN` loads a new output and error on every accepted sample. It stays in this state until reset.

Top module: `tsd_dlms_top`

## Requirements
Definitions used below:
- G = 2^TREE_P is the number of taps per group.
- M = N_TAPS/G is the number of groups.
- Tap k belongs to group j = floor(k/G).
- Samples are numbered 0, 1, 2, … in the order they are accepted after reset.
- w_k[c] is coefficient k after sample c has been accepted.

- R1: After reset, every coefficient is 0, `y_out` and `err_out` are 0, and `out_valid` is low.
- R2: On the clock that accepts sample s, `out_valid` goes high (for one cycle) exactly when s >= M+1. The outputs then belong to sample n = s-1-M. While the controller is in `ST_FILL`, `y_out` and `err_out` stay 0.
- R3: y(n) = floor( sum over k of w_k[n+j] * x(n-k) / 2^FRAC_W ). Samples with a negative index count as 0.
- R4: err(n) = d(n) - y(n), computed without loss in `ERR_W` bits.
- R5: When sample s is accepted, tap k in group j adds floor( err(m) * x(m-k) / 2^MU_SHIFT ), where m = s-M-3-j. The adaptation delay therefore grows by one sample per group. Terms with m < 0 add nothing.
- R6: When an update would leave the range of a `COEF_W`-bit signed value, the coefficient is set to the nearer limit: 2^(COEF_W-1)-1 or -2^(COEF_W-1).
- R7: A clock with `in_valid` low changes no coefficient, no output and no pipeline state, and `out_valid` is low after it.
- R8: `coef_rd` shows coefficient number `coef_sel` combinationally, with tap 0 applied to the newest sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Accept `x_in` and `d_in` this clock |
| x_in | input | DATA_W | Signed input sample |
| d_in | input | DATA_W | Signed desired-response sample |
| y_out | output | COEF_W+DATA_W+clog2(N_TAPS)+1-FRAC_W | Signed filter output |
| err_out | output | y_out width + 1 | Signed error, desired minus output |
| out_valid | output | 1 | New `y_out`/`err_out` loaded this cycle |
| coef_sel | input | clog2(N_TAPS) | Coefficient index to read |
| coef_rd | output | COEF_W | Signed coefficient selected by `coef_sel` |

## Verification
The bound checker assumes three things about the inputs:
- `in_valid` is always a known level after reset.
- `coef_sel` matters only on cycles where it is held; the coefficient-hold property makes no claim on a cycle where the index moves.
- The only event that may move the outputs or the coefficients is an accepted sample.

The stimulus stays inside these assumptions. It changes inputs only at the falling edge, drops `in_valid` on a fixed pattern to create stalls, and steps `coef_sel` through every index during both stalled and running cycles. It also keeps the desired samples inside `DATA_W` bits by clamping the reference system's output. The long saturation phases keep adaptation running for thousands of samples against constant targets that no coefficient set in range can reach.

// File: rtl/tsd_pkg.sv
package tsd_pkg;

    typedef enum logic [0:0] {
        ST_FILL = 1'b0,
        ST_RUN  = 1'b1
    } tsd_state_e;

endpackage

// File: rtl/tsd_tree.sv
module tsd_tree #(
    parameter int TREE_P = 1,
    parameter int W      = 24
) (
    input  logic signed [W-1:0] leaf [1 << TREE_P],
    output logic signed [W-1:0] root
);
    localparam int G = 1 << TREE_P;

    // Level l holds G >> l nodes; level 0 is the leaves.
    for (genvar l = 0; l <= TREE_P; l++) begin : g_lvl
        logic signed [W-1:0] v [G >> l];
        if (l == 0) begin : g_leaf
            for (genvar i = 0; i < G; i++) begin : g_i
                assign v[i] = leaf[i];
            end
        end else begin : g_add
            for (genvar i = 0; i < (G >> l); i++) begin : g_i
                assign v[i] = g_lvl[l-1].v[2*i] + g_lvl[l-1].v[2*i+1];
            end
        end
    end

    assign root = g_lvl[TREE_P].v[0];

endmodule

// File: rtl/tsd_ctrl.sv
module tsd_ctrl
    import tsd_pkg::*;
#(
    parameter int LAT = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    output logic load_out,
    output logic out_valid,
    output logic run_mode
);
    localparam int CW = $clog2(LAT + 1);

    tsd_state_e     state_q, state_d;
    logic [CW-1:0]  cnt_q;
    logic           fill_last;

    assign fill_last = (cnt_q == CW'(LAT));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_FILL;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FILL: if (step && fill_last) state_d = ST_RUN;
            ST_RUN:  state_d = ST_RUN;
        endcase
    end

    // Fill counter, only meaningful in ST_FILL
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (step && state_q == ST_FILL && !fill_last) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    assign load_out = step && (state_q == ST_RUN || fill_last);
    assign run_mode = (state_q == ST_RUN);

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
        end else begin
            out_valid <= load_out;
        end
    end

endmodule

// File: rtl/tsd_pe.sv
module tsd_pe #(
    parameter int DATA_W   = 8,
    parameter int COEF_W   = 12,
    parameter int ACC_W    = 24,
    parameter int ERR_W    = 17,
    parameter int TREE_P   = 1,
    parameter int MU_SHIFT = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     step,
    input  logic signed [DATA_W-1:0] x_tap [1 << TREE_P],
    input  logic signed [DATA_W-1:0] x_upd [1 << TREE_P],
    input  logic signed [ERR_W-1:0]  err_in,
    input  logic signed [ACC_W-1:0]  psum_in,
    output logic signed [ACC_W-1:0]  psum_out,
    output logic signed [COEF_W-1:0] coef [1 << TREE_P]
);
    localparam int G      = 1 << TREE_P;
    localparam int FPRD_W = COEF_W + DATA_W;
    localparam int UPRD_W = ERR_W + DATA_W;
    localparam int SUM_W  = UPRD_W + 1;
    localparam logic signed [SUM_W-1:0] LIM_HI = SUM_W'((64'sd1 <<< (COEF_W - 1)) - 64'sd1);
    localparam logic signed [SUM_W-1:0] LIM_LO = SUM_W'(-(64'sd1 <<< (COEF_W - 1)));

    logic signed [ACC_W-1:0]  leaf [G];
    logic signed [ACC_W-1:0]  tree_sum;
    logic signed [COEF_W-1:0] coef_nx [G];

    for (genvar i = 0; i < G; i++) begin : g_tap
        logic signed [FPRD_W-1:0] fprod;
        logic signed [UPRD_W-1:0] uprod;
        logic signed [UPRD_W-1:0] delta;
        logic signed [SUM_W-1:0]  wsum;

        assign fprod = FPRD_W'(coef[i]) * FPRD_W'(x_tap[i]);
        assign leaf[i] = ACC_W'(fprod);

        assign uprod = UPRD_W'(err_in) * UPRD_W'(x_upd[i]);
        assign delta = uprod >>> MU_SHIFT;
        assign wsum  = SUM_W'(coef[i]) + SUM_W'(delta);

        always_comb begin
            if (wsum > LIM_HI) begin
                coef_nx[i] = LIM_HI[COEF_W-1:0];
            end else if (wsum < LIM_LO) begin
                coef_nx[i] = LIM_LO[COEF_W-1:0];
            end else begin
                coef_nx[i] = wsum[COEF_W-1:0];
            end
        end
    end

    tsd_tree #(
        .TREE_P (TREE_P),
        .W      (ACC_W)
    ) u_tree (
        .leaf (leaf),
        .root (tree_sum)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            psum_out <= '0;
            for (int i = 0; i < G; i++) coef[i] <= '0;
        end else if (step) begin
            psum_out <= psum_in + tree_sum;
            for (int i = 0; i < G; i++) coef[i] <= coef_nx[i];
        end
    end

endmodule

// File: rtl/tsd_dlms_top.sv
module tsd_dlms_top #(
    parameter int N_TAPS   = 8,
    parameter int TREE_P   = 1,
    parameter int DATA_W   = 8,
    parameter int COEF_W   = 12,
    parameter int FRAC_W   = 8,
    parameter int MU_SHIFT = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic signed [DATA_W-1:0] x_in,
    input  logic signed [DATA_W-1:0] d_in,
    output logic signed [COEF_W+DATA_W+$clog2(N_TAPS)+1-FRAC_W-1:0] y_out,
    output logic signed [COEF_W+DATA_W+$clog2(N_TAPS)+2-FRAC_W-1:0] err_out,
    output logic                     out_valid,
    input  logic [$clog2(N_TAPS)-1:0] coef_sel,
    output logic signed [COEF_W-1:0] coef_rd
);
    localparam int G      = 1 << TREE_P;
    localparam int NUM_PE = N_TAPS / G;
    localparam int ACC_W  = COEF_W + DATA_W + $clog2(N_TAPS) + 1;
    localparam int Y_W    = ACC_W - FRAC_W;
    localparam int ERR_W  = Y_W + 1;
    localparam int XL     = N_TAPS + 2*NUM_PE + 1;
    localparam int LAT    = NUM_PE + 1;

    logic signed [DATA_W-1:0] x_line [XL];
    logic signed [DATA_W-1:0] d_line [NUM_PE+1];
    logic signed [ACC_W-1:0]  psum   [NUM_PE+1];
    logic signed [ERR_W-1:0]  ecopy  [NUM_PE];
    logic signed [COEF_W-1:0] coef_all [N_TAPS];
    logic signed [Y_W-1:0]    y_next;
    logic signed [ERR_W-1:0]  err_next;
    logic                     load_out;
    logic                     run_mode;

    tsd_ctrl #(
        .LAT (LAT)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .step      (in_valid),
        .load_out  (load_out),
        .out_valid (out_valid),
        .run_mode  (run_mode)
    );

    // Sample and desired-response delay lines
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < XL; i++) x_line[i] <= '0;
            for (int i = 0; i <= NUM_PE; i++) d_line[i] <= '0;
        end else if (in_valid) begin
            x_line[0] <= x_in;
            for (int i = 1; i < XL; i++) x_line[i] <= x_line[i-1];
            d_line[0] <= d_in;
            for (int i = 1; i <= NUM_PE; i++) d_line[i] <= d_line[i-1];
        end
    end

    assign psum[0] = '0;

    for (genvar j = 0; j < NUM_PE; j++) begin : g_pe
        logic signed [DATA_W-1:0] xt [G];
        logic signed [DATA_W-1:0] xu [G];
        logic signed [COEF_W-1:0] pc [G];

        for (genvar i = 0; i < G; i++) begin : g_w
            assign xt[i] = x_line[j*G + i + j];
            assign xu[i] = x_line[NUM_PE + 2 + j + j*G + i];
            assign coef_all[j*G + i] = pc[i];
        end

        tsd_pe #(
            .DATA_W   (DATA_W),
            .COEF_W   (COEF_W),
            .ACC_W    (ACC_W),
            .ERR_W    (ERR_W),
            .TREE_P   (TREE_P),
            .MU_SHIFT (MU_SHIFT)
        ) u_pe (
            .clk      (clk),
            .rst_n    (rst_n),
            .step     (in_valid),
            .x_tap    (xt),
            .x_upd    (xu),
            .err_in   (ecopy[j]),
            .psum_in  (psum[j]),
            .psum_out (psum[j+1]),
            .coef     (pc)
        );
    end

    // Error feedback chain: one registered copy per group
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int j = 0; j < NUM_PE; j++) ecopy[j] <= '0;
        end else if (in_valid) begin
            ecopy[0] <= err_out;
            for (int j = 1; j < NUM_PE; j++) ecopy[j] <= ecopy[j-1];
        end
    end

    assign y_next   = psum[NUM_PE][ACC_W-1:FRAC_W];
    assign err_next = ERR_W'(d_line[NUM_PE]) - ERR_W'(y_next);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            y_out   <= '0;
            err_out <= '0;
        end else if (load_out) begin
            y_out   <= y_next;
            err_out <= err_next;
        end
    end

    assign coef_rd = coef_all[coef_sel];

endmodule

// File: rtl/tsd_dlms_chk.sv
module tsd_dlms_chk #(
    parameter int N_TAPS = 8,
    parameter int DATA_W = 8,
    parameter int COEF_W = 12,
    parameter int FRAC_W = 8
) (
    input logic clk,
    input logic rst_n,
    input logic in_valid,
    input logic out_valid,
    input logic run_mode,
    input logic signed [COEF_W+DATA_W+$clog2(N_TAPS)+1-FRAC_W-1:0] y_out,
    input logic signed [COEF_W+DATA_W+$clog2(N_TAPS)+2-FRAC_W-1:0] err_out,
    input logic [$clog2(N_TAPS)-1:0] coef_sel,
    input logic signed [COEF_W-1:0] coef_rd
);
    // R7
    stall_novalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R7
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(y_out) && $stable(err_out)));

    // R7
    stall_coef_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!$stable(coef_sel) || $stable(coef_rd)));

    // R2
    run_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && in_valid) |=> out_valid);

    // R2
    valid_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> run_mode);

    // R1
    fill_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_mode |-> (y_out == '0 && err_out == '0));

endmodule

bind tsd_dlms_top tsd_dlms_chk #(
    .N_TAPS (N_TAPS),
    .DATA_W (DATA_W),
    .COEF_W (COEF_W),
    .FRAC_W (FRAC_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .run_mode  (run_mode),
    .y_out     (y_out),
    .err_out   (err_out),
    .coef_sel  (coef_sel),
    .coef_rd   (coef_rd)
);

// File: tb/tsd_dlms_top_bench.sv
`timescale 1ns/1ps
module tsd_dlms_top_bench;
    localparam int N  = 8;
    localparam int G  = 2;
    localparam int M  = N / G;
    localparam int FR = 8;
    localparam int MU = 6;
    localparam longint WHI = 2047;
    localparam longint WLO = -2048;

    logic clk = 1'b0;
    logic rst_n;
    logic in_valid;
    logic signed [7:0]  x_in, d_in;
    logic signed [15:0] y_out;
    logic signed [16:0] err_out;
    logic out_valid;
    logic [2:0] coef_sel;
    logic signed [11:0] coef_rd;

    always #5 clk = ~clk;

    tsd_dlms_top u_tsd_dlms_top (
        .clk (clk), .rst_n (rst_n), .in_valid (in_valid),
        .x_in (x_in), .d_in (d_in), .y_out (y_out), .err_out (err_out),
        .out_valid (out_valid), .coef_sel (coef_sel), .coef_rd (coef_rd)
    );

    int n_chk = 0;
    int n_err = 0;

    // Behavioural model state: rings indexed by accepted-sample number
    longint xh [64];
    longint dh [64];
    longint yh [64];
    longint eh [64];
    longint wr [16][N];
    int     s_cnt = 0;
    int     sel = 0;
    longint gx [N];
    longint hsys [N] = '{40, -25, 12, 6, -3, 2, 0, 1};

    task automatic chk(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint xat(int i);
        return (i < 0) ? 0 : xh[i % 64];
    endfunction

    function automatic longint eat(int i);
        return (i < 0) ? 0 : eh[i % 64];
    endfunction

    // R3 R4 R5 R6 behavioural delayed-LMS step
    task automatic model_step(input longint xv, input longint dv);
        int s = s_cnt;
        int n = s - 1 - M;
        xh[s % 64] = xv;
        dh[s % 64] = dv;
        for (int k = 0; k < N; k++) begin
            int j = k / G;
            int m = s - 3 - M - j;
            longint w = wr[s % 16][k];
            if (m >= 0) begin
                w = w + ((eat(m) * xat(m - k)) >>> MU);
                if (w > WHI) w = WHI;
                if (w < WLO) w = WLO;
            end
            wr[(s + 1) % 16][k] = w;
        end
        if (n >= 0) begin
            longint acc = 0;
            for (int k = 0; k < N; k++)
                acc += wr[(n + k / G + 1) % 16][k] * xat(n - k);
            yh[n % 64] = acc >>> FR;
            eh[n % 64] = dh[n % 64] - yh[n % 64];
        end
        s_cnt++;
    endtask

    task automatic run_cycle(input bit v, input int xv, input int dv);
        longint pre_y = longint'(y_out);
        longint pre_e = longint'(err_out);
        in_valid = v;
        x_in     = 8'(xv);
        d_in     = 8'(dv);
        coef_sel = 3'(sel);
        @(posedge clk);
        if (v) model_step(longint'(xv), longint'(dv));
        @(negedge clk);
        if (v) begin
            int si = s_cnt - 1;
            if (si >= M + 1) begin
                int n = si - 1 - M;
                chk("R2 out_valid", longint'(out_valid), 1);
                chk("R3 y_out", longint'(y_out), yh[n % 64]);
                chk("R4 err_out", longint'(err_out), eh[n % 64]);
            end else begin
                chk("R2 fill out_valid", longint'(out_valid), 0);
                chk("R2 fill y_out", longint'(y_out), 0);
                chk("R2 fill err_out", longint'(err_out), 0);
            end
            chk("R5 R8 coef", longint'(coef_rd), wr[s_cnt % 16][sel]);
        end else begin
            chk("R7 out_valid", longint'(out_valid), 0);
            chk("R7 y_out", longint'(y_out), pre_y);
            chk("R7 err_out", longint'(err_out), pre_e);
            chk("R7 R8 coef", longint'(coef_rd), wr[s_cnt % 16][sel]);
        end
        sel = (sel + 3) % N;
    endtask

    task automatic check_all_coef(input string req, input longint exp);
        for (int k = 0; k < N; k++) begin
            coef_sel = 3'(k);
            #1;
            chk(req, longint'(coef_rd), exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; x_in = '0; d_in = '0; coef_sel = '0;
        for (int i = 0; i < 64; i++) begin xh[i] = 0; dh[i] = 0; yh[i] = 0; eh[i] = 0; end
        for (int r = 0; r < 16; r++) for (int k = 0; k < N; k++) wr[r][k] = 0;
        for (int k = 0; k < N; k++) gx[k] = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk("R1 out_valid", longint'(out_valid), 0);
        chk("R1 y_out", longint'(y_out), 0);
        chk("R1 err_out", longint'(err_out), 0);
        check_all_coef("R1 coef", 0);

        // R7 stall before any sample
        repeat (3) run_cycle(1'b0, 5, 5);

        // R3 R4 R5: identify an unknown system with periodic stalls
        for (int c = 0; c < 700; c++) begin
            bit v = (c % 7) != 3;
            int xv = int'($urandom_range(80)) - 40;
            int dv = 0;
            if (v) begin
                longint t = 0;
                for (int k = N - 1; k > 0; k--) gx[k] = gx[k-1];
                gx[0] = xv;
                for (int k = 0; k < N; k++) t += hsys[k] * gx[k];
                t = t >>> 6;
                if (t > 127) t = 127;
                if (t < -128) t = -128;
                dv = int'(t);
            end
            run_cycle(v, xv, dv);
        end

        // R6 drive toward the positive limit
        for (int c = 0; c < 4500; c++) run_cycle((c % 11) != 5, 1, 127);
        check_all_coef("R6 upper saturation", WHI);

        // R6 drive toward the negative limit
        for (int c = 0; c < 4500; c++) run_cycle((c % 13) != 2, 1, -128);
        check_all_coef("R6 lower saturation", WLO);

        // R7 stall after running
        repeat (4) run_cycle(1'b0, 9, -9);

        finish_run();
    end

endmodule